// File: doc/BRIEF.md
# Periodic Battery Health Monitor

This block schedules load tests of a backup cell and keeps a warning flag that tells the system the cell is weak. A free-running time-base tick drives two counters. One counts the wait between tests. The other counts how long the load stays connected. While the load is connected, the block takes in a synchronized comparator result each cycle; a high level means the cell has sagged below its trip voltage. When a test ends with any low reading, the warning pull-down is enabled.

The power supervisor provides a run-enable. It is high only once the supply is valid and the write-protect recovery period has ended. While it is low, the block sits idle, ignores ticks and keeps its warning as it is. A power-up event pulse requests a retest. That retest runs as soon as the block is running, even if the warning is already set, so a valid verdict exists within one test pulse of the supply becoming valid. A passing periodic test never clears the warning. A passing power-up retest clears it. The warning output is an open-drain style pull-down enable: 1 means pull the line low, meaning the cell is weak.

The sequencer has three states:
- `ST_OFF`: idle.
- `ST_WAIT`: counting the interval.
- `ST_TEST`: load connected.

Its transitions are:
- **enable** (`ST_OFF`→`ST_WAIT`)
- **retest** (`ST_OFF`→`ST_TEST` or `ST_WAIT`→`ST_TEST`, when a retest is pending)
- **due** (`ST_WAIT`→`ST_TEST`, after the interval)
- **finish** (`ST_TEST`→`ST_WAIT`)
- **drop** (any state→`ST_OFF` when run-enable falls)

Top module: `bat_health_mon`

## Requirements
- R1: After reset, `load_en_o` and `warn_pd_o` are both 0 and no retest is pending.
- R2: While `run_i` is 0, ticks are ignored and `load_en_o` is 0 from the cycle after `run_i` falls. A fall during a test ends the test at once, and `warn_pd_o` keeps its value.
- R3: While running with no retest pending, a test starts (`load_en_o` goes to 1) in the cycle after the INTERVAL_TICKS-th tick. Ticks are counted from zero on entering the running state and again from zero at the end of each test.
- R4: `load_en_o` stays 1 for exactly PULSE_TICKS ticks and returns to 0 in the cycle after the PULSE_TICKS-th tick of the test.
- R5: The comparator input `low_i` is sampled in every cycle of a test, including the cycle of the final tick. If any sample is 1, `warn_pd_o` becomes 1 in the cycle after the test completes.
- R6: A periodic test that passes leaves `warn_pd_o` unchanged, so a set warning stays set.
- R7: A `pwrup_i` pulse marks a retest as pending, and the mark survives while `run_i` is 0. The retest starts in the cycle after `run_i` is seen high, or in the cycle after the mark appears while waiting, whether or not `warn_pd_o` is set.
- R8: A passing power-up retest clears `warn_pd_o`. The interval then restarts from zero.
- R9: A `pwrup_i` pulse in the completion cycle of a power-up retest marks a new retest, which starts one cycle after that completion.
- R10: If `run_i` falls in the cycle of a test's final tick, the power failure wins. No verdict is applied, and `warn_pd_o` is unchanged.
- R11: `warn_pd_o` changes only in the cycle right after a cycle in which `load_en_o` was 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle time-base tick |
| run_i | input | 1 | Supply valid and write protection released |
| pwrup_i | input | 1 | One-cycle power-up event |
| low_i | input | 1 | Synchronized comparator: cell below trip |
| load_en_o | output | 1 | Connect the test load |
| warn_pd_o | output | 1 | Enable the warning line pull-down |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is a test's completion and a loss of `run_i`. The bench drops `run_i` together with the final tick while holding `low_i` high. It then expects the load released and the warning still clear, which shows that the failure took priority over the verdict.

The second pair is the completion of a power-up retest and a fresh `pwrup_i` pulse. The bench expects the warning cleared by the pass, `load_en_o` low for one cycle, and then high again as the new retest starts.

// File: rtl/bhm_pkg.sv
`timescale 1ns/1ps
package bhm_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_TEST = 2'd2
    } bhm_state_e;

    // width needed to count 0 .. n-1, never below one bit
    function automatic int ctr_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bhm_tick_ctr.sv
`timescale 1ns/1ps
module bhm_tick_ctr #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic step_i,
    output logic last_o
);
    localparam int W = bhm_pkg::ctr_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/bhm_fsm.sv
`timescale 1ns/1ps
module bhm_fsm
    import bhm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       tick_i,
    input  logic       pend_i,
    input  logic       ivl_last_i,
    input  logic       pw_last_i,
    output bhm_state_e state_o,
    output logic       ivl_clr_o,
    output logic       ivl_step_o,
    output logic       pw_clr_o,
    output logic       pw_step_o,
    output logic       start_o,
    output logic       done_o,
    output logic       load_o
);
    bhm_state_e state_q, state_d;

    // next-state selection; losing run_i overrides everything
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (run_i) state_d = pend_i ? ST_TEST : ST_WAIT;
            end
            ST_WAIT: begin
                if (!run_i)                     state_d = ST_OFF;
                else if (pend_i)                state_d = ST_TEST;
                else if (tick_i && ivl_last_i)  state_d = ST_TEST;
            end
            ST_TEST: begin
                if (!run_i)                     state_d = ST_OFF;
                else if (tick_i && pw_last_i)   state_d = ST_WAIT;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // outputs decoded from the current state
    always_comb begin
        ivl_clr_o  = 1'b1;
        ivl_step_o = 1'b0;
        pw_clr_o   = 1'b1;
        pw_step_o  = 1'b0;
        load_o     = 1'b0;
        done_o     = 1'b0;
        unique case (state_q)
            ST_OFF: begin
            end
            ST_WAIT: begin
                ivl_clr_o  = 1'b0;
                ivl_step_o = tick_i;
            end
            ST_TEST: begin
                pw_clr_o  = 1'b0;
                pw_step_o = tick_i;
                load_o    = 1'b1;
                done_o    = run_i && tick_i && pw_last_i;
            end
            default: begin
            end
        endcase
        start_o = (state_d == ST_TEST) && (state_q != ST_TEST);
    end

    assign state_o = state_q;
endmodule

// File: rtl/bhm_verdict.sv
`timescale 1ns/1ps
module bhm_verdict (
    input  logic clk,
    input  logic rst_n,
    input  logic pwrup_i,
    input  logic start_i,
    input  logic testing_i,
    input  logic done_i,
    input  logic low_i,
    output logic pend_o,
    output logic warn_o
);
    logic pend_q;   // retest requested, not yet completed
    logic kind_q;   // running test was a power-up retest
    logic fail_q;   // a low reading has been seen in this test
    logic warn_q;
    logic verdict;

    assign verdict = fail_q | low_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            kind_q <= 1'b0;
            fail_q <= 1'b0;
            warn_q <= 1'b0;
        end else begin
            if (pwrup_i)               pend_q <= 1'b1;
            else if (done_i && kind_q) pend_q <= 1'b0;

            if (start_i) kind_q <= pend_q;

            if (testing_i && !done_i) fail_q <= verdict;
            else                      fail_q <= 1'b0;

            if (done_i) begin
                if (verdict)     warn_q <= 1'b1;
                else if (kind_q) warn_q <= 1'b0;
            end
        end
    end

    assign pend_o = pend_q;
    assign warn_o = warn_q;
endmodule

// File: rtl/bat_health_mon.sv
`timescale 1ns/1ps
module bat_health_mon
    import bhm_pkg::*;
#(
    parameter int INTERVAL_TICKS = 86400,
    parameter int PULSE_TICKS    = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic run_i,
    input  logic pwrup_i,
    input  logic low_i,
    output logic load_en_o,
    output logic warn_pd_o
);
    bhm_state_e state;
    logic pend, ivl_last, pw_last;
    logic ivl_clr, ivl_step, pw_clr, pw_step;
    logic start, done, load;

    bhm_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_i),
        .tick_i     (tick_i),
        .pend_i     (pend),
        .ivl_last_i (ivl_last),
        .pw_last_i  (pw_last),
        .state_o    (state),
        .ivl_clr_o  (ivl_clr),
        .ivl_step_o (ivl_step),
        .pw_clr_o   (pw_clr),
        .pw_step_o  (pw_step),
        .start_o    (start),
        .done_o     (done),
        .load_o     (load)
    );

    bhm_tick_ctr #(.LIMIT(INTERVAL_TICKS)) u_ivl_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (ivl_clr),
        .step_i (ivl_step),
        .last_o (ivl_last)
    );

    bhm_tick_ctr #(.LIMIT(PULSE_TICKS)) u_pw_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (pw_clr),
        .step_i (pw_step),
        .last_o (pw_last)
    );

    bhm_verdict u_verdict (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwrup_i   (pwrup_i),
        .start_i   (start),
        .testing_i (state == ST_TEST),
        .done_i    (done),
        .low_i     (low_i),
        .pend_o    (pend),
        .warn_o    (warn_pd_o)
    );

    assign load_en_o = load;
endmodule

// File: rtl/bhm_checker.sv
`timescale 1ns/1ps
module bhm_checker #(
    parameter int PULSE_TICKS = 1
) (
    input logic clk,
    input logic rst_n,
    input logic tick_i,
    input logic run_i,
    input logic load_en_o,
    input logic warn_pd_o
);
    int unsigned load_ticks;

    always_ff @(posedge clk) begin
        if (!rst_n || !load_en_o) load_ticks <= 0;
        else if (tick_i)          load_ticks <= load_ticks + 1;
    end

    a_r2_drop_releases_load: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !load_en_o);

    a_r4_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        load_en_o |-> (load_ticks < PULSE_TICKS));

    a_r7_start_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_en_o) |-> $past(run_i));

    a_r10_fail_keeps_warn: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en_o && !run_i) |=> $stable(warn_pd_o));

    a_r11_warn_moves_after_test: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(warn_pd_o) |-> $past(load_en_o));
endmodule

bind bat_health_mon bhm_checker #(.PULSE_TICKS(PULSE_TICKS)) u_bhm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .run_i     (run_i),
    .load_en_o (load_en_o),
    .warn_pd_o (warn_pd_o)
);

// File: tb/bat_health_mon_bench.sv
`timescale 1ns/1ps
module bat_health_mon_bench;
    localparam int IVL = 4;
    localparam int PW  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0, run_i = 1'b0, pwrup_i = 1'b0, low_i = 1'b0;
    logic load_en_o, warn_pd_o;

    typedef struct {
        string req;
        logic  load;
        logic  warn;
    } exp_t;

    exp_t sb[$];
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bat_health_mon #(.INTERVAL_TICKS(IVL), .PULSE_TICKS(PW)) u_bat_health_mon (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_i),
        .pwrup_i(pwrup_i), .low_i(low_i),
        .load_en_o(load_en_o), .warn_pd_o(warn_pd_o)
    );

    // monitor: compare queued expectations at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (load_en_o !== e.load || warn_pd_o !== e.warn) begin
                bad++;
                $display("FAIL %s: load=%b warn=%b expected load=%b warn=%b",
                         e.req, load_en_o, warn_pd_o, e.load, e.warn);
            end
        end
    end

    // apply inputs for one clock and return just after the edge
    task automatic drive(input bit r, input bit p, input bit t, input bit l);
        run_i = r; pwrup_i = p; tick_i = t; low_i = l;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string req, input bit load, input bit warn);
        exp_t e;
        e.req = req; e.load = load; e.warn = warn;
        sb.push_back(e);
    endtask

    // run a passing periodic wait: IVL-1 ticks quiet, then test starts
    task automatic wait_interval(input string req, input bit warn);
        for (int i = 0; i < IVL - 1; i++) begin
            drive(1, 0, 1, 0);
            expect_out(req, 0, warn);
        end
        drive(1, 0, 1, 0);
        expect_out(req, 1, warn);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        drive(0, 0, 0, 0);
        expect_out("R1", 0, 0);

        // ticks while not running do nothing
        for (int i = 0; i < 6; i++) drive(0, 0, 1, 0);
        expect_out("R2", 0, 0);

        // power-up retest, pending across run low
        drive(0, 1, 0, 0);
        expect_out("R7", 0, 0);
        drive(1, 0, 0, 0);
        expect_out("R7", 1, 0);
        drive(1, 0, 1, 0); expect_out("R4", 1, 0);
        drive(1, 0, 1, 0); expect_out("R4", 1, 0);
        drive(1, 0, 1, 0); expect_out("R4", 0, 0);

        // periodic test with a low reading mid-test
        wait_interval("R3", 0);
        drive(1, 0, 0, 1); expect_out("R5", 1, 0);
        drive(1, 0, 1, 0);
        drive(1, 0, 1, 0);
        drive(1, 0, 1, 0); expect_out("R5", 0, 1);

        // periodic pass keeps the warning
        wait_interval("R3", 1);
        for (int i = 0; i < PW; i++) drive(1, 0, 1, 0);
        expect_out("R6", 0, 1);

        // power failure in the middle of a test
        wait_interval("R3", 1);
        drive(1, 0, 1, 0);
        drive(0, 0, 0, 1); expect_out("R2", 0, 1);
        drive(0, 0, 1, 0); expect_out("R2", 0, 1);
        drive(1, 0, 0, 0); expect_out("R3", 0, 1);
        wait_interval("R3", 1);
        for (int i = 0; i < PW; i++) drive(1, 0, 1, 0);
        expect_out("R6", 0, 1);

        // power-up retest passes while warning set: cleared
        drive(0, 0, 0, 0);
        drive(0, 1, 0, 0);
        drive(1, 0, 0, 0); expect_out("R7", 1, 1);
        for (int i = 0; i < PW; i++) drive(1, 0, 1, 0);
        expect_out("R8", 0, 0);
        wait_interval("R8", 0);
        // low only in the final tick cycle
        drive(1, 0, 1, 0);
        drive(1, 0, 1, 0);
        drive(1, 0, 1, 1); expect_out("R5", 0, 1);

        // power-up pulse in completion cycle of a retest
        drive(0, 0, 0, 0);
        drive(0, 1, 0, 0);
        drive(1, 0, 0, 0); expect_out("R7", 1, 1);
        drive(1, 0, 1, 0);
        drive(1, 0, 1, 0);
        drive(1, 1, 1, 0); expect_out("R9", 0, 0);
        drive(1, 0, 0, 0); expect_out("R9", 1, 0);
        for (int i = 0; i < PW; i++) drive(1, 0, 1, 0);
        expect_out("R9", 0, 0);

        // power failure in the final tick cycle with a low reading
        wait_interval("R3", 0);
        drive(1, 0, 1, 0);
        drive(1, 0, 1, 0);
        drive(0, 0, 1, 1); expect_out("R10", 0, 0);
        drive(1, 0, 0, 0); expect_out("R10", 0, 0);
        wait_interval("R10", 0);

        @(negedge clk);
        #1;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule